// File: doc/BRIEF.md
# Receive Timestamp Header Inserter

This block sits on the receive packet path. For each incoming frame, it can place a 16-byte time header in front of the frame's first beat. The header holds two 64-bit timestamps. Each slot takes its value from one of two free-running timers, and both timers are captured on a start-of-frame event pulse that arrives ahead of the frame data. Each timer value is packed as 32 bits of seconds above 32 bits of nanoseconds.

Every receive queue has its own set of control bits: one enable bit, and one timer-select bit for each of the two header slots. The queue index travels with the stream and is read on the first beat of a frame. When a queue is enabled, every frame on it gets a header, whatever the frame contains. When a queue is disabled, its frames pass straight through with no added cycle. The output is a valid/ready stream. Backpressure on the output stalls both the header and the payload. Correcting the timestamp for link-speed latency is handled further downstream.

Top module: `rxts_prepend`

## Requirements
- R1: When the enable bit of the queue on `inQueue` is 0, the output carries the input beat in the same cycle. Data, start and end markers are unchanged, `outValid` equals `inValid`, and `inReady` equals `outReady`.
- R2: When the enable bit is 1, exactly HDR_BEATS = 16/DATA_BYTES header beats come out before the frame's first beat. `outSof` is 1 on the first header beat only and is cleared on the original first beat. `outEof` is 0 on every header beat.
- R3: Header byte n goes on data bits [8m+7:8m] of header beat n/DATA_BYTES, where m = n mod DATA_BYTES. The byte order is little-endian. Bytes 0-3 hold slot 0 nanoseconds, bytes 4-7 hold slot 0 seconds, bytes 8-11 hold slot 1 nanoseconds, and bytes 12-15 hold slot 1 seconds. Slot 1 therefore starts at byte 8.
- R4: For each slot, a select bit of 0 in `cfgSel0`/`cfgSel1` picks `timer0` and a select bit of 1 picks `timer1`. Each timer input is {seconds[63:32], nanoseconds[31:0]}.
- R5: The header holds both timer values as they were in the last cycle in which `tsEvent` was high and no header beat was being offered. Pulses that arrive while a header beat is being offered, including during a stall, are ignored.
- R6: While `outValid` is 1 and `outReady` is 0, the output beat stays unchanged into the next cycle, and no input beat is consumed during header beats.
- R7: After the header, the payload beats come out unchanged and in order. Each frame grows by exactly HDR_BEATS beats.
- R8: Every frame on an enabled queue is stamped, whatever its contents.
- R9: After reset, both timer snapshots are zero, and no output beat appears without an input beat.
- R10: The enable and select bits are looked up in the per-queue vectors at the index given by `inQueue` on the frame's first beat. Bit q belongs to queue q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tsEvent | input | 1 | Start-of-frame event pulse that captures both timers |
| timer0 | input | 64 | Timer 0, {seconds, nanoseconds} |
| timer1 | input | 64 | Timer 1, {seconds, nanoseconds} |
| cfgEnable | input | NUM_QUEUES | Per-queue header enable |
| cfgSel0 | input | NUM_QUEUES | Per-queue timer select for slot 0 |
| cfgSel1 | input | NUM_QUEUES | Per-queue timer select for slot 1 |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted |
| inData | input | 8*DATA_BYTES | Input beat, little-endian bytes |
| inSof | input | 1 | First beat of frame |
| inEof | input | 1 | Last beat of frame |
| inQueue | input | QUEUE_W | Receive queue of the frame |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream ready |
| outData | output | 8*DATA_BYTES | Output beat |
| outSof | output | 1 | First beat of output frame |
| outEof | output | 1 | Last beat of output frame |

## Verification
The bench sweeps every queue against all eight combinations of enable and the two slot selects. The other queues are always given the opposite settings, so reading the wrong queue index shows up as a wrong header or as a missing header. Frame lengths run from one to four beats, which puts the end marker on the same beat as the start marker and on later beats. Runs with full output readiness are mixed with stall patterns, and some frames see `tsEvent` toggling while their header is stalled. These patterns tell a correct capture instant apart from a late one. One stamped frame right after reset, with no event pulse, shows the zero reset snapshot. The two timers count at different rates, so a swapped slot or a swapped seconds/nanoseconds word shows up as a wrong value.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

  // Fixed size of the prepended time header in bytes.
  localparam int HDR_BYTES = 16;
  // Widest header beat index (one-byte beats give 16 header beats).
  localparam int IDX_MAX_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_FIRST = 2'd2
  } stateE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                 emitHdr;
    logic [IDX_MAX_W-1:0] hdrIdx;
    logic                 clearSof;
  } strobeS;

endpackage

// File: rtl/rxts_ctrl.sv
module rxts_ctrl
  import rxts_pkg::*;
#(
  parameter int HDR_BEATS = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inSof,
  input  logic   queueEn,
  input  logic   outReady,
  output logic   inReady,
  output logic   outValid,
  output strobeS strb
);

  localparam logic [IDX_MAX_W-1:0] LAST_IDX = IDX_MAX_W'(HDR_BEATS - 1);

  stateE                st, stNext;
  logic [IDX_MAX_W-1:0] cnt, cntNext;
  logic                 trig;

  assign trig = inValid && inSof && queueEn;

  always_comb begin
    stNext   = st;
    cntNext  = cnt;
    strb     = '0;
    inReady  = outReady;
    outValid = inValid;
    unique case (st)
      ST_IDLE: begin
        if (trig) begin
          // Hold the first frame beat and offer header beat 0 instead.
          inReady      = 1'b0;
          outValid     = 1'b1;
          strb.emitHdr = 1'b1;
          strb.hdrIdx  = '0;
          if (outReady) begin
            if (LAST_IDX == '0) begin
              stNext = ST_FIRST;
            end else begin
              stNext  = ST_HDR;
              cntNext = IDX_MAX_W'(1);
            end
          end
        end
      end
      ST_HDR: begin
        inReady      = 1'b0;
        outValid     = 1'b1;
        strb.emitHdr = 1'b1;
        strb.hdrIdx  = cnt;
        if (outReady) begin
          if (cnt == LAST_IDX) begin
            stNext  = ST_FIRST;
            cntNext = '0;
          end else begin
            cntNext = cnt + IDX_MAX_W'(1);
          end
        end
      end
      ST_FIRST: begin
        // Original first beat follows the header; its start marker moves to the header.
        strb.clearSof = 1'b1;
        if (inValid && outReady) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  // Checker state: header beats accepted for the current frame.
  logic [IDX_MAX_W:0] chkBeats;
  always_ff @(posedge clk) begin
    if (!rstN) chkBeats <= '0;
    else if (strb.emitHdr && outReady) chkBeats <= chkBeats + 1'b1;
    else if (st == ST_FIRST) chkBeats <= '0;
  end

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HDR && !outReady) |=> (st == ST_HDR && $stable(cnt)))
    else $error("header beat moved during stall"); // R6

  AST_HDR_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FIRST && $past(st) != ST_FIRST) |-> (chkBeats == (IDX_MAX_W+1)'(HDR_BEATS)))
    else $error("wrong header beat count"); // R2

  AST_FIRST_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FIRST && inValid && outReady) |=> (st == ST_IDLE))
    else $error("first payload beat not released"); // R7

endmodule

// File: rtl/rxts_datapath.sv
module rxts_datapath
  import rxts_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int HDR_BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tsEvent,
  input  logic [63:0]             timer0,
  input  logic [63:0]             timer1,
  input  logic                    sel0,
  input  logic                    sel1,
  input  logic [8*DATA_BYTES-1:0] inData,
  input  logic                    inSof,
  input  logic                    inEof,
  input  strobeS                  strb,
  output logic [8*DATA_BYTES-1:0] outData,
  output logic                    outSof,
  output logic                    outEof
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int IDX_W  = (HDR_BEATS > 1) ? $clog2(HDR_BEATS) : 1;

  logic [63:0]          snap0, snap1;
  logic [63:0]          slot0, slot1;
  logic [8*HDR_BYTES-1:0] hdrVec;
  logic [DATA_W-1:0]    hdrWords [HDR_BEATS];
  logic [DATA_W-1:0]    hdrWord;

  // Snapshot both timers on the event pulse; frozen while a header beat is offered.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snap0 <= '0;
      snap1 <= '0;
    end else if (tsEvent && !strb.emitHdr) begin
      snap0 <= timer0;
      snap1 <= timer1;
    end
  end

  assign slot0  = sel0 ? snap1 : snap0;
  assign slot1  = sel1 ? snap1 : snap0;
  // Little-endian: byte 0 is slot 0 ns LSB, byte 8 starts slot 1.
  assign hdrVec = {slot1, slot0};

  for (genvar k = 0; k < HDR_BEATS; k++) begin : g_word
    assign hdrWords[k] = hdrVec[k*DATA_W +: DATA_W];
  end

  assign hdrWord = hdrWords[strb.hdrIdx[IDX_W-1:0]];

  always_comb begin
    if (strb.emitHdr) begin
      outData = hdrWord;
      outSof  = (strb.hdrIdx == '0);
      outEof  = 1'b0;
    end else begin
      outData = inData;
      outSof  = inSof && !strb.clearSof;
      outEof  = inEof;
    end
  end

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitHdr |=> ($stable(snap0) && $stable(snap1)))
    else $error("snapshot changed during header"); // R5

endmodule

// File: rtl/rxts_prepend.sv
module rxts_prepend
  import rxts_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int NUM_QUEUES = 4,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int QUEUE_W   = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tsEvent,
  input  logic [63:0]           timer0,
  input  logic [63:0]           timer1,
  input  logic [NUM_QUEUES-1:0] cfgEnable,
  input  logic [NUM_QUEUES-1:0] cfgSel0,
  input  logic [NUM_QUEUES-1:0] cfgSel1,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [DATA_W-1:0]     inData,
  input  logic                  inSof,
  input  logic                  inEof,
  input  logic [QUEUE_W-1:0]    inQueue,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [DATA_W-1:0]     outData,
  output logic                  outSof,
  output logic                  outEof
);

  localparam int HDR_BEATS = HDR_BYTES / DATA_BYTES;

  logic   queueEn, qSel0, qSel1;
  strobeS strb;

  if (NUM_QUEUES == 1) begin : g_oneq
    assign queueEn = cfgEnable[0];
    assign qSel0   = cfgSel0[0];
    assign qSel1   = cfgSel1[0];
  end else begin : g_multiq
    assign queueEn = cfgEnable[inQueue];
    assign qSel0   = cfgSel0[inQueue];
    assign qSel1   = cfgSel1[inQueue];
  end

  rxts_ctrl #(.HDR_BEATS(HDR_BEATS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSof    (inSof),
    .queueEn  (queueEn),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  rxts_datapath #(.DATA_BYTES(DATA_BYTES), .HDR_BEATS(HDR_BEATS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tsEvent (tsEvent),
    .timer0  (timer0),
    .timer1  (timer1),
    .sel0    (qSel0),
    .sel1    (qSel1),
    .inData  (inData),
    .inSof   (inSof),
    .inEof   (inEof),
    .strb    (strb),
    .outData (outData),
    .outSof  (outSof),
    .outEof  (outEof)
  );

endmodule

// File: tb/rxts_prepend_tb.sv
module rxts_prepend_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NQ         = 4;
  localparam int EXP_DEPTH  = 512;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tsEvent;
  logic [63:0] timer0, timer1;
  logic [NQ-1:0] cfgEnable, cfgSel0, cfgSel1;
  logic        inValid, inReady, inSof, inEof;
  logic [31:0] inData;
  logic [1:0]  inQueue;
  logic        outValid, outReady, outSof, outEof;
  logic [31:0] outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign timer0 = {32'(cyc * 3 + 100), 32'(cyc * 7)};
  assign timer1 = {32'(cyc) ^ 32'hA5A5_0000, 32'(cyc * 13 + 5)};

  rxts_prepend #(.DATA_BYTES(4), .NUM_QUEUES(NQ)) u_dut (
    .clk(clk), .rstN(rstN), .tsEvent(tsEvent), .timer0(timer0), .timer1(timer1),
    .cfgEnable(cfgEnable), .cfgSel0(cfgSel0), .cfgSel1(cfgSel1),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof),
    .inEof(inEof), .inQueue(inQueue), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSof(outSof), .outEof(outEof)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expData [EXP_DEPTH];
  logic        expSof  [EXP_DEPTH];
  logic        expEof  [EXP_DEPTH];
  string       expTag  [EXP_DEPTH];
  int wrPtr = 0;
  int rdPtr = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(logic [31:0] d, logic s, logic e, string tag);
    expData[wrPtr] = d;
    expSof[wrPtr]  = s;
    expEof[wrPtr]  = e;
    expTag[wrPtr]  = tag;
    wrPtr++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Output monitor: 2 time units after each falling edge.
  logic        holdPend = 1'b0;
  logic [31:0] holdData;
  logic        holdSof, holdEof;
  always @(negedge clk) begin
    #2;
    if (!done && cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      done = 1'b1;
      summary();
    end
    if (rstN) begin
      if (holdPend) begin
        // R6: stalled beat must not change
        check(outValid && outData == holdData && outSof == holdSof && outEof == holdEof,
              "R6 stall hold", {outData, 29'(0), outValid, outSof, outEof},
              {holdData, 29'(0), 1'b1, holdSof, holdEof});
      end
      holdPend = outValid && !outReady;
      holdData = outData;
      holdSof  = outSof;
      holdEof  = outEof;
      if (outValid && outReady) begin
        if (rdPtr >= wrPtr) begin
          check(1'b0, "R7 extra output beat", {32'(0), outData}, 64'(0));
        end else begin
          check(outData == expData[rdPtr] && outSof == expSof[rdPtr] && outEof == expEof[rdPtr],
                expTag[rdPtr], {outData, 30'(0), outSof, outEof},
                {expData[rdPtr], 30'(0), expSof[rdPtr], expEof[rdPtr]});
          rdPtr++;
        end
      end
    end
  end

  function automatic logic [31:0] payload(int f, int b);
    return {8'(f), 8'(b), 16'(f * 37 + b * 11)};
  endfunction

  // One frame: optional event pulse, then beats until all are accepted.
  task automatic runFrame(int q, bit en, bit s0, bit s1, int f, int len,
                          bit stall, bit noise, bit pulse);
    logic [63:0] e0, e1, slot0, slot1;
    logic [NQ-1:0] qBit;
    int b;
    qBit = NQ'(1) << q;
    @(negedge clk);
    cfgEnable = en ? qBit : ~qBit;
    cfgSel0   = s0 ? qBit : ~qBit;
    cfgSel1   = s1 ? qBit : ~qBit;
    inValid   = 1'b0;
    outReady  = 1'b1;
    tsEvent   = pulse;
    #1;
    e0 = pulse ? timer0 : 64'(0);
    e1 = pulse ? timer1 : 64'(0);
    if (!pulse) begin
      e0 = 64'(0);
      e1 = 64'(0);
    end
    if (en) begin
      slot0 = s0 ? e1 : e0;
      slot1 = s1 ? e1 : e0;
      // R3 R4 R5 R10 layout: ns0, sec0, ns1, sec1
      pushExp(slot0[31:0],  1'b1, 1'b0, "R2 R3 R4 R5 R8 R10 header beat 0");
      pushExp(slot0[63:32], 1'b0, 1'b0, "R3 R4 R5 header beat 1");
      pushExp(slot1[31:0],  1'b0, 1'b0, "R3 R4 R5 header beat 2");
      pushExp(slot1[63:32], 1'b0, 1'b0, "R3 R4 R5 header beat 3");
    end
    for (int k = 0; k < len; k++)
      pushExp(payload(f, k), (k == 0) && !en, k == len - 1,
              en ? "R2 R7 payload after header" : "R1 R10 pass-through beat");
    b = 0;
    while (b < len) begin
      @(negedge clk);
      tsEvent  = noise;
      inValid  = 1'b1;
      inData   = payload(f, b);
      inSof    = (b == 0);
      inEof    = (b == len - 1);
      inQueue  = 2'(q);
      outReady = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (!en) begin
        check(outValid && outData == inData && outSof == inSof && outEof == inEof
              && inReady == outReady, "R1 same-cycle pass-through",
              {outData, 28'(0), outValid, outSof, outEof, inReady},
              {inData, 28'(0), 1'b1, inSof, inEof, outReady});
      end
      if (inValid && inReady) b++;
    end
    @(negedge clk);
    inValid  = 1'b0;
    tsEvent  = 1'b0;
    outReady = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; tsEvent = 1'b0; inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    inData = '0; inQueue = '0; outReady = 1'b1;
    cfgEnable = '0; cfgSel0 = '0; cfgSel1 = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(!outValid, "R9 no output after reset", {63'(0), outValid}, 64'(0));

    // R9: header from zero snapshot, no event pulse since reset
    runFrame(0, 1'b1, 1'b0, 1'b1, 200, 2, 1'b0, 1'b0, 1'b0);

    for (int q = 0; q < NQ; q++) begin
      for (int c = 0; c < 8; c++) begin
        int f;
        f = q * 8 + c;
        runFrame(q, c[0], c[1], c[2], f, 1 + (f % 4), f[0], (f % 3) == 0, 1'b1);
      end
    end

    repeat (4) @(negedge clk);
    #1;
    check(rdPtr == wrPtr, "R7 beat count", 64'(rdPtr), 64'(wrPtr));
    check(!outValid, "R9 idle after traffic", {63'(0), outValid}, 64'(0));
    done = 1'b1;
    summary();
  end

endmodule